// File: doc/BRIEF.md
# Hundreds-Bounded Storage Clear Engine

This block executes a storage-clear operation for a decimal-addressed character memory. After a start strobe it writes a blank character with no word mark into one memory position at a time. It begins at a start address and moves toward lower addresses. It stops once it has cleared the nearest position at or below the start whose address is an exact multiple of 100. The stop depends only on that address boundary and never on memory contents, so one operation clears between 1 and 100 positions.

An instruction length code selects the addressing form. In the chained form the current value of the B-address register is the start address. In the one-address form the first operand field is the start. In the two-address form the first field becomes the next-instruction address (a branch target) and clearing starts at the second field. Every other length is rejected as illegal and nothing is written. When the operation ends, the B-address register holds the address just below the last cleared boundary. Clearing position 0 makes the register wrap to the top of the 16,000-position memory.

The engine runs in one of two modes. In run mode it clears one position on every clock. In step mode it clears one position for each step request. A sequencer moves between four states:
- IDLE waits for start.
- IDLE to CLEAR on a legal start.
- IDLE to FAULT on an illegal length.
- CLEAR stays in CLEAR after each write that is not on a boundary. This is the "continue" transition.
- CLEAR to FINISH on the write to the boundary position.
- FINISH to IDLE and FAULT to IDLE after one cycle each.

Top module: `stclr_engine`

## Requirements
- R1: Writes go to strictly descending addresses starting at the start address. The last write is to the first address at or below the start whose value is a multiple of 100, so one operation makes (start mod 100)+1 writes, at most 100.
- R2: Every write carries character code 0 (blank) on `mem_char` and a low `mem_wm`, which removes any word mark.
- R3: `len_code` 1 starts at the current `b_reg` value, and 4 starts at `fld_first`. Any value other than 1, 4 or 7 raises `illegal` for exactly one cycle, the cycle after start. In that case there is no write, `busy` stays low, and `b_reg` and `next_addr` are unchanged.
- R4: With `len_code` 7, `next_addr` takes `fld_first` and clearing starts at `fld_second`. With `len_code` 1 or 4, `next_addr` takes `nsi_addr`. `next_addr` is loaded in the cycle after start.
- R5: After the last write, `b_reg` holds the cleared boundary address minus one.
- R6: When the cleared boundary is address 0, `b_reg` becomes 15999. `b_reg` never exceeds 15999.
- R7: In step mode (`step_mode`=1) a write happens in exactly those CLEAR cycles where `step_req` is high. `done` is raised only after the step that clears the boundary, and the engine stays busy between steps.
- R8: In run mode the first write happens in the cycle after start and then one write per clock. `busy` is high from the cycle after start through the last write. `done` is a single-cycle pulse in the cycle after the last write.
- R9: A start strobe while the engine is busy, finishing or faulted has no effect on writes, `b_reg` or `next_addr`.
- R10: After reset the engine is idle with `b_reg` and `next_addr` at 0 and `busy`, `done`, `illegal` and `mem_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, taken only when idle |
| len_code | input | 3 | Instruction length: 1 chained, 4 one-address, 7 two-address |
| fld_first | input | 14 | First operand field |
| fld_second | input | 14 | Second operand field (two-address start) |
| nsi_addr | input | 14 | Address of the next sequential instruction |
| step_mode | input | 1 | 1 = single-step, 0 = run |
| step_req | input | 1 | Step request, one write per high cycle in step mode |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 14 | Memory write address |
| mem_char | output | 6 | Character written (always blank) |
| mem_wm | output | 1 | Word-mark bit written (always 0) |
| b_reg | output | 14 | B-address register |
| next_addr | output | 14 | Next-instruction address |
| busy | output | 1 | Clearing in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-length flag |

## Verification
Properties checked on every cycle:
- Each write carries a blank character and no word mark.
- Consecutive writes descend by one address.
- Each `done` follows a write to a multiple of 100 and leaves `b_reg` one below it, or at 15999 for address 0.
- `done` never lasts two cycles.
- `illegal` never coincides with a write.
- Step-mode writes occur only with a step request.

Only the bench scenarios can show the following, by comparing every cycle against a behavioural model:
- Which start address each length form selects.
- Where the branch target comes from.
- That a start strobe during an operation is ignored.
- That the number of writes equals the start's remainder plus one.

// File: rtl/stclr_pkg.sv
package stclr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_FINISH,
        ST_FAULT
    } stclr_state_e;

    typedef enum logic [1:0] {
        FORM_CHAIN,
        FORM_ONE,
        FORM_TWO,
        FORM_BAD
    } stclr_form_e;

endpackage

// File: rtl/stclr_decode.sv
module stclr_decode
    import stclr_pkg::*;
#(
    parameter int LEN_W     = 3,
    parameter int LEN_CHAIN = 1,
    parameter int LEN_ONE   = 4,
    parameter int LEN_TWO   = 7
) (
    input  logic [LEN_W-1:0] len_code,
    output stclr_form_e      form
);

    always_comb begin
        if (len_code == LEN_W'(LEN_CHAIN)) begin
            form = FORM_CHAIN;
        end else if (len_code == LEN_W'(LEN_ONE)) begin
            form = FORM_ONE;
        end else if (len_code == LEN_W'(LEN_TWO)) begin
            form = FORM_TWO;
        end else begin
            form = FORM_BAD;
        end
    end

endmodule

// File: rtl/stclr_addr.sv
module stclr_addr #(
    parameter int ADDR_W   = 14,
    parameter int TOP_ADDR = 15999,
    parameter int BOUNDARY = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              dec,
    output logic [ADDR_W-1:0] addr,
    output logic              at_bound
);

    localparam int REM_W  = $clog2(BOUNDARY);
    localparam int WIDE_W = 2 * ADDR_W;

    logic [REM_W-1:0] rem_q;

    // Remainder by conditional subtraction of shifted boundary values (no divider)
    function automatic logic [REM_W-1:0] rem_of(input logic [ADDR_W-1:0] v);
        logic [WIDE_W-1:0] r;
        logic [WIDE_W-1:0] d;
        r = WIDE_W'(v);
        for (int k = ADDR_W - 1; k >= 0; k--) begin
            d = WIDE_W'(BOUNDARY) << k;
            if (r >= d) begin
                r = r - d;
            end
        end
        return r[REM_W-1:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr  <= '0;
            rem_q <= '0;
        end else if (load) begin
            addr  <= load_val;
            rem_q <= rem_of(load_val);
        end else if (dec) begin
            if (rem_q == '0) begin
                addr <= (addr == '0) ? ADDR_W'(TOP_ADDR) : addr - 1'b1;
            end else begin
                addr  <= addr - 1'b1;
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign at_bound = (rem_q == '0);

endmodule

// File: rtl/stclr_ctrl.sv
module stclr_ctrl
    import stclr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  stclr_form_e form,
    input  logic        step_mode,
    input  logic        step_req,
    input  logic        at_bound,
    output logic        load,
    output logic        wr,
    output logic        busy,
    output logic        done,
    output logic        illegal
);

    stclr_state_e state_q;
    stclr_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (form == FORM_BAD) ? ST_FAULT : ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                if (wr && at_bound) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load    = 1'b0;
        wr      = 1'b0;
        busy    = 1'b0;
        done    = 1'b0;
        illegal = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load = start && (form != FORM_BAD);
            end
            ST_CLEAR: begin
                busy = 1'b1;
                wr   = !step_mode || step_req;
            end
            ST_FINISH: done    = 1'b1;
            ST_FAULT:  illegal = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/stclr_engine.sv
module stclr_engine
    import stclr_pkg::*;
#(
    parameter int ADDR_W   = 14,
    parameter int TOP_ADDR = 15999,
    parameter int BOUNDARY = 100,
    parameter int CHAR_W   = 6,
    parameter int LEN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [ADDR_W-1:0] fld_first,
    input  logic [ADDR_W-1:0] fld_second,
    input  logic [ADDR_W-1:0] nsi_addr,
    input  logic              step_mode,
    input  logic              step_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CHAR_W-1:0] mem_char,
    output logic              mem_wm,
    output logic [ADDR_W-1:0] b_reg,
    output logic [ADDR_W-1:0] next_addr,
    output logic              busy,
    output logic              done,
    output logic              illegal
);

    stclr_form_e       form;
    logic              load;
    logic              wr;
    logic              at_bound;
    logic [ADDR_W-1:0] start_val;
    logic [ADDR_W-1:0] addr;

    stclr_decode #(.LEN_W(LEN_W)) u_decode (
        .len_code (len_code),
        .form     (form)
    );

    stclr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .form      (form),
        .step_mode (step_mode),
        .step_req  (step_req),
        .at_bound  (at_bound),
        .load      (load),
        .wr        (wr),
        .busy      (busy),
        .done      (done),
        .illegal   (illegal)
    );

    always_comb begin
        unique case (form)
            FORM_ONE: start_val = fld_first;
            FORM_TWO: start_val = fld_second;
            default:  start_val = addr;
        endcase
    end

    stclr_addr #(
        .ADDR_W   (ADDR_W),
        .TOP_ADDR (TOP_ADDR),
        .BOUNDARY (BOUNDARY)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (start_val),
        .dec      (wr),
        .addr     (addr),
        .at_bound (at_bound)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_addr <= '0;
        end else if (load) begin
            next_addr <= (form == FORM_TWO) ? fld_first : nsi_addr;
        end
    end

    assign mem_we   = wr;
    assign mem_addr = addr;
    assign mem_char = '0;
    assign mem_wm   = 1'b0;
    assign b_reg    = addr;

endmodule

// File: rtl/stclr_engine_chk.sv
module stclr_engine_chk #(
    parameter int ADDR_W   = 14,
    parameter int TOP_ADDR = 15999,
    parameter int BOUNDARY = 100,
    parameter int CHAR_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_mode,
    input logic              step_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [CHAR_W-1:0] mem_char,
    input logic              mem_wm,
    input logic [ADDR_W-1:0] b_reg,
    input logic              busy,
    input logic              done,
    input logic              illegal
);

    AST_BLANK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_char == '0) && !mem_wm);  // R2

    AST_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - 1'b1));  // R1

    AST_STOP_AT_HUNDRED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_we) && (($past(mem_addr) % BOUNDARY) == 0)));  // R1

    AST_FINAL_B: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (b_reg == (($past(mem_addr) == '0) ? ADDR_W'(TOP_ADDR)
                                                   : $past(mem_addr) - 1'b1)));  // R5

    AST_B_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        b_reg <= ADDR_W'(TOP_ADDR));  // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R8

    AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);  // R8

    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_we && !busy));  // R3

    AST_STEP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && step_mode) |-> step_req);  // R7

endmodule

bind stclr_engine stclr_engine_chk #(
    .ADDR_W   (ADDR_W),
    .TOP_ADDR (TOP_ADDR),
    .BOUNDARY (BOUNDARY),
    .CHAR_W   (CHAR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_mode (step_mode),
    .step_req  (step_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_char  (mem_char),
    .mem_wm    (mem_wm),
    .b_reg     (b_reg),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/stclr_engine_test.sv
module stclr_engine_test;

    localparam int PERIOD = 10;
    localparam int TOP    = 15999;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  len_code = 3'd0;
    logic [13:0] fld_first = '0;
    logic [13:0] fld_second = '0;
    logic [13:0] nsi_addr = '0;
    logic        step_mode = 1'b0;
    logic        step_req = 1'b0;
    logic        mem_we;
    logic [13:0] mem_addr;
    logic [5:0]  mem_char;
    logic        mem_wm;
    logic [13:0] b_reg;
    logic [13:0] next_addr;
    logic        busy;
    logic        done;
    logic        illegal;

    stclr_engine uut (
        .clk (clk), .rst_n (rst_n), .start (start), .len_code (len_code),
        .fld_first (fld_first), .fld_second (fld_second), .nsi_addr (nsi_addr),
        .step_mode (step_mode), .step_req (step_req),
        .mem_we (mem_we), .mem_addr (mem_addr), .mem_char (mem_char), .mem_wm (mem_wm),
        .b_reg (b_reg), .next_addr (next_addr),
        .busy (busy), .done (done), .illegal (illegal)
    );

    always #(PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Behavioural model: 0 idle, 1 clearing, 2 finishing, 3 fault
    int m_state = 0;
    int m_b     = 0;
    int m_next  = 0;
    int wr_count = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit m_write();
        return (m_state == 1) && (!step_mode || step_req);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_b = 0; m_next = 0;
        end else begin
            case (m_state)
                0: if (start) begin
                    if (len_code == 3'd1 || len_code == 3'd4 || len_code == 3'd7) begin
                        if (len_code == 3'd4) m_b = int'(fld_first);
                        if (len_code == 3'd7) m_b = int'(fld_second);
                        m_next = (len_code == 3'd7) ? int'(fld_first) : int'(nsi_addr);
                        m_state = 1;
                    end else begin
                        m_state = 3;
                    end
                end
                1: if (m_write()) begin
                    wr_count++;
                    if (m_b % 100 == 0) begin
                        m_b = (m_b == 0) ? TOP : m_b - 1;
                        m_state = 2;
                    end else begin
                        m_b = m_b - 1;
                    end
                end
                default: m_state = 0;
            endcase
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(busy == (m_state == 1), "R8 busy", int'(busy), int'(m_state == 1));
            chk(done == (m_state == 2), "R8 done", int'(done), int'(m_state == 2));
            chk(illegal == (m_state == 3), "R3 illegal", int'(illegal), int'(m_state == 3));
            chk(mem_we == m_write(), "R7 mem_we", int'(mem_we), int'(m_write()));
            chk(int'(b_reg) == m_b, "R5 b_reg", int'(b_reg), m_b);
            chk(int'(next_addr) == m_next, "R4 next_addr", int'(next_addr), m_next);
            if (mem_we) begin
                chk(int'(mem_addr) == m_b, "R1 mem_addr", int'(mem_addr), m_b);
                chk(mem_char == 6'd0 && !mem_wm, "R2 blank", int'({mem_wm, mem_char}), 0);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [2:0] len, input int f1, input int f2, input int nsi);
        len_code = len; fld_first = 14'(f1); fld_second = 14'(f2); nsi_addr = 14'(nsi);
        start = 1'b1;
        tick(1);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && m_state != 0; i++) tick(1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        tick(2);
        // R10: reset state
        chk(!busy && !done && !illegal && !mem_we, "R10 flags", int'({busy, done, illegal, mem_we}), 0);
        chk(b_reg == 0 && next_addr == 0, "R10 regs", int'(b_reg) + int'(next_addr), 0);
        rst_n = 1'b1;
        tick(2);

        // R1/R8: one-address, start 1234 clears 1234..1200
        wr_count = 0;
        issue(3'd4, 1234, 0, 77);
        chk(busy, "R8 busy after start", int'(busy), 1);
        wait_idle();
        chk(wr_count == 35, "R1 write count 1234", wr_count, 35);
        chk(b_reg == 1199, "R5 b_reg after 1234", int'(b_reg), 1199);
        chk(next_addr == 77, "R4 nsi next", int'(next_addr), 77);

        // R4: two-address, branch target from first field, start at 2399
        wr_count = 0;
        issue(3'd7, 500, 2399, 88);
        wait_idle();
        chk(wr_count == 100, "R1 full hundred", wr_count, 100);
        chk(next_addr == 500, "R4 branch target", int'(next_addr), 500);
        chk(b_reg == 2299, "R5 b_reg after 2399", int'(b_reg), 2299);

        // R3: chained form continues from b_reg = 2299
        wr_count = 0;
        issue(3'd1, 9999, 9999, 12);
        wait_idle();
        chk(wr_count == 100, "R3 chained count", wr_count, 100);
        chk(b_reg == 2199, "R3 chained b_reg", int'(b_reg), 2199);

        // R6: boundary 0 wraps to top
        wr_count = 0;
        issue(3'd4, 42, 0, 5);
        wait_idle();
        chk(wr_count == 43, "R6 count to zero", wr_count, 43);
        chk(b_reg == 15999, "R6 wrap", int'(b_reg), 15999);

        // R1: start exactly on a boundary clears one position
        wr_count = 0;
        issue(3'd4, 300, 0, 6);
        wait_idle();
        chk(wr_count == 1, "R1 single write", wr_count, 1);
        chk(b_reg == 299, "R5 b_reg after 300", int'(b_reg), 299);

        // R1: top of memory
        wr_count = 0;
        issue(3'd1, 0, 0, 6);
        wait_idle();
        chk(wr_count == 100, "R1 from 299", wr_count, 100);
        issue(3'd4, 15999, 0, 6);
        wait_idle();
        chk(b_reg == 15899, "R5 after 15999", int'(b_reg), 15899);

        // R3: illegal lengths leave everything untouched
        for (int l = 0; l < 8; l++) begin
            if (l != 1 && l != 4 && l != 7) begin
                wr_count = 0;
                issue(3'(l), 700, 800, 900);
                chk(illegal, "R3 illegal flag", int'(illegal), 1);
                tick(1);
                chk(!illegal && wr_count == 0, "R3 illegal no write", wr_count, 0);
                chk(b_reg == 15899 && next_addr == 6, "R3 regs kept", int'(b_reg), 15899);
            end
        end

        // R9: start while busy is ignored
        wr_count = 0;
        issue(3'd4, 3150, 0, 11);
        tick(3);
        issue(3'd7, 40, 60, 22);
        wait_idle();
        chk(wr_count == 51, "R9 count unchanged", wr_count, 51);
        chk(b_reg == 3099 && next_addr == 11, "R9 regs", int'(b_reg), 3099);

        // R7: step mode, one write per request with gaps
        step_mode = 1'b1;
        wr_count = 0;
        issue(3'd4, 205, 0, 33);
        tick(4);
        chk(wr_count == 0 && busy, "R7 no step no write", wr_count, 0);
        for (int s = 0; s < 6; s++) begin
            step_req = 1'b1;
            tick(1);
            step_req = 1'b0;
            if (s < 5) chk(busy && !done, "R7 continue", int'(done), 0);
            else chk(done, "R7 done on boundary step", int'(done), 1);
            tick(2);
        end
        chk(wr_count == 6 && b_reg == 199, "R7 step total", wr_count, 6);
        step_mode = 1'b0;

        tick(3);
        finish_run();
    end

endmodule